// File: doc/BRIEF.md
# Half-to-Full Width Packet Packer

This block joins a packet stream carried in 16-bit halves into a packet stream carried in 32-bit words. Each input word has 19 bits: a 16-bit payload, a packet-start flag, a packet-end flag and a flag that marks a final half holding only one valid byte. Each output word has 36 bits: a 32-bit payload, the same two packet flags and a 2-bit code that gives how many bytes of the word are valid. Both sides use a ready/valid handshake. A word moves across a port only in a cycle where the sender's valid and the receiver's ready are both high.

Consecutive input halves are paired. The first half of a pair waits in a single holding register. The second half completes the word, which is then loaded into the output register. When a packet ends on the first half of a pair, the block sends that half at once as a partial word and zeroes the lower half. The next packet therefore always begins on a fresh 32-bit word. There is no storage apart from the holding register and the output register.

Top module: `pk16to32_packer`

## Requirements
- R1: After reset, `out_vld` is low and `in_rdy` is high.
- R2: In a paired word, the first accepted half fills bits 31:16 and the second fills bits 15:0. Output SOP (bit 32) comes from the first half and output EOP (bit 33) from the second. Input fields are bit 18 = half-full, bit 17 = EOP, bit 16 = SOP, bits 15:0 = data.
- R3: A half with EOP that arrives as the first half of a pair is sent as its own word with EOP set and bits 15:0 zero. Its code (bits 35:34) is 01 when the half-full flag is set and 10 otherwise.
- R4: A half with EOP that arrives as the second half of a pair gives code 11 when the half-full flag is set and 00 otherwise.
- R5: A paired word without EOP carries EOP = 0 and code 00.
- R6: While `out_vld` is high and `out_rdy` is low, the output word and `out_vld` stay unchanged in the next cycle.
- R7: While a word waits at the output and `out_rdy` is low, `in_rdy` is low. Every accepted half appears exactly once, in order.
- R8: After a half with EOP is accepted, the next accepted half is treated as the first half of a new pair.
- R9: Reset empties the holding register, so a half accepted before reset never reaches the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_word | input | 19 | Input half: {half_full, eop, sop, data[15:0]} |
| in_vld | input | 1 | Upstream offers a half |
| in_rdy | output | 1 | Block can take a half this cycle |
| out_word | output | 36 | Output word: {code[1:0], eop, sop, data[31:0]} |
| out_vld | output | 1 | Block offers a word |
| out_rdy | input | 1 | Downstream takes the word this cycle |

## Verification
A half that completes a word, or a first half that carries EOP, is accepted on one rising edge. The resulting word is visible at the output right after that edge, one register later. `in_rdy` is a combinational function of the output register and `out_rdy` in the same cycle. The bench sets its inputs at the falling edge and lets them settle. It then reads `in_rdy`, `out_vld` and `out_word` before the next rising edge, so each check sees exactly the values that decide the transfer on that edge. Stall stability (R6) is checked at the falling edge one cycle after a stall was observed.

// File: rtl/pk_pkg.sv
package pk_pkg;

  // Code for a word that closes a packet on its upper half only.
  function automatic logic [1:0] occ_early(input logic half_full);
    return half_full ? 2'b01 : 2'b10;
  endfunction

  // Code for a word made of two halves.
  function automatic logic [1:0] occ_pair(input logic eop, input logic half_full);
    return (eop && half_full) ? 2'b11 : 2'b00;
  endfunction

endpackage

// File: rtl/pk_upper_hold.sv
module pk_upper_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         clear,
  input  logic [W-1:0] d_data,
  input  logic         d_sop,
  output logic         vld,
  output logic [W-1:0] data,
  output logic         sop
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= 1'b0;
      data <= '0;
      sop  <= 1'b0;
    end else if (load) begin
      vld  <= 1'b1;
      data <= d_data;
      sop  <= d_sop;
    end else if (clear) begin
      vld  <= 1'b0;
    end
  end

endmodule

// File: rtl/pk_word_reg.sv
module pk_word_reg #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         unload,
  input  logic [W-1:0] d,
  output logic         vld,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
      q   <= '0;
    end else if (load) begin
      vld <= 1'b1;
      q   <= d;
    end else if (unload) begin
      vld <= 1'b0;
    end
  end

endmodule

// File: rtl/pk16to32_packer.sv
module pk16to32_packer #(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [HALF_W+2:0]     in_word,
  input  logic                  in_vld,
  output logic                  in_rdy,
  output logic [2*HALF_W+3:0]   out_word,
  output logic                  out_vld,
  input  logic                  out_rdy
);
  import pk_pkg::*;

  localparam int IN_W    = HALF_W + 3;
  localparam int OUT_W   = 2 * HALF_W + 4;
  localparam int I_SOP   = HALF_W;
  localparam int I_EOP   = HALF_W + 1;
  localparam int I_HALF  = HALF_W + 2;
  localparam int O_SOP   = 2 * HALF_W;
  localparam int O_EOP   = 2 * HALF_W + 1;
  localparam int O_OCC_L = 2 * HALF_W + 2;

  logic [HALF_W-1:0] in_data;
  logic              in_sop, in_eop, in_half;
  logic              hold_vld, hold_sop;
  logic [HALF_W-1:0] hold_data;
  logic              in_fire, out_fire;
  logic              early_flush, park_upper, pair_done, load_out;
  logic [OUT_W-1:0]  next_word;

  assign in_data = in_word[HALF_W-1:0];
  assign in_sop  = in_word[I_SOP];
  assign in_eop  = in_word[I_EOP];
  assign in_half = in_word[I_HALF];

  assign in_rdy   = !out_vld || out_rdy;
  assign in_fire  = in_vld && in_rdy;
  assign out_fire = out_vld && out_rdy;

  assign early_flush = in_fire && !hold_vld && in_eop;
  assign park_upper  = in_fire && !hold_vld && !in_eop;
  assign pair_done   = in_fire && hold_vld;
  assign load_out    = early_flush || pair_done;

  always_comb begin
    if (hold_vld)
      next_word = {occ_pair(in_eop, in_half), in_eop, hold_sop, hold_data, in_data};
    else
      next_word = {occ_early(in_half), 1'b1, in_sop, in_data, {HALF_W{1'b0}}};
  end

  pk_upper_hold #(.W(HALF_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .load   (park_upper),
    .clear  (pair_done),
    .d_data (in_data),
    .d_sop  (in_sop),
    .vld    (hold_vld),
    .data   (hold_data),
    .sop    (hold_sop)
  );

  pk_word_reg #(.W(OUT_W)) u_out (
    .clk    (clk),
    .rst    (rst),
    .load   (load_out),
    .unload (out_fire),
    .d      (next_word),
    .vld    (out_vld),
    .q      (out_word)
  );

  // R7
  stall_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_rdy) |-> !in_rdy);

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_rdy) |=> (out_vld && $stable(out_word)));

  // R3
  early_flush_chk: assert property (@(posedge clk) disable iff (rst)
    early_flush |=> (out_vld && out_word[O_EOP] && out_word[HALF_W-1:0] == '0 &&
                     out_word[O_OCC_L+1] != out_word[O_OCC_L]));

  // R4
  pair_end_chk: assert property (@(posedge clk) disable iff (rst)
    (pair_done && in_eop) |=> (out_vld && out_word[O_EOP] &&
                               out_word[O_OCC_L+1] == out_word[O_OCC_L]));

  // R8
  boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (in_fire && in_eop) |=> !hold_vld);

  // R2
  pair_sop_chk: assert property (@(posedge clk) disable iff (rst)
    pair_done |=> (out_vld && out_word[O_SOP] == $past(hold_sop)));

endmodule

// File: tb/pk16to32_packer_tb.sv
module pk16to32_packer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 100000;

  logic        clk = 1'b0;
  logic        rst;
  logic [18:0] in_word;
  logic        in_vld;
  logic        in_rdy;
  logic [35:0] out_word;
  logic        out_vld;
  logic        out_rdy;

  always #(CLK_PERIOD/2) clk = ~clk;

  pk16to32_packer u_dut (
    .clk(clk), .rst(rst), .in_word(in_word), .in_vld(in_vld), .in_rdy(in_rdy),
    .out_word(out_word), .out_vld(out_vld), .out_rdy(out_rdy)
  );

  logic [18:0] inq  [0:1023];
  int          inmd [0:1023];
  logic [35:0] expq [0:511];
  int in_n, exp_n, in_rd, exp_rd, checks, fails, cyc;
  logic [7:0]  lfsr;
  logic        prev_stall;
  logic [35:0] prev_word;

  task automatic check(input bit ok, input string tag, input logic [35:0] act,
                       input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [35:0] w);
    if (w[33] && w[15:0] == 16'h0 && (w[35:34] == 2'b01 || w[35:34] == 2'b10)) return "R3";
    if (w[33]) return "R4";
    return "R5/R2";
  endfunction

  initial begin
    in_n = 0; exp_n = 0;
    // Packets: length 1..9 halves, last half full or half-full, three pacing modes
    for (int md = 0; md < 3; md++)
      for (int hf = 0; hf < 2; hf++)
        for (int len = 1; len <= 9; len++) begin
          int pk;
          logic [15:0] h [0:8];
          pk = md * 18 + hf * 9 + len;
          for (int i = 0; i < len; i++) begin
            h[i] = {pk[7:0], i[7:0]} ^ 16'h5A3C;
            inq[in_n]  = {(hf == 1) && (i == len - 1), i == len - 1, i == 0, h[i]};
            inmd[in_n] = md;
            in_n++;
          end
          for (int i = 0; i < len; i += 2) begin
            if (i + 1 < len) begin
              logic e;
              e = (i + 1 == len - 1);
              expq[exp_n] = {(e && hf == 1) ? 2'b11 : 2'b00, e, i == 0, h[i], h[i+1]};
            end else begin
              expq[exp_n] = {hf == 1 ? 2'b01 : 2'b10, 1'b1, i == 0, h[i], 16'h0000};
            end
            exp_n++;
          end
        end
  end

  initial begin
    checks = 0; fails = 0; cyc = 0; in_rd = 0; exp_rd = 0;
    lfsr = 8'h1;
    prev_stall = 1'b0; prev_word = '0;
    rst = 1'b1; in_vld = 1'b0; in_word = '0; out_rdy = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1
    check(out_vld == 1'b0, "R1 out_vld", {35'b0, out_vld}, 36'h0);
    check(in_rdy == 1'b1, "R1 in_rdy", {35'b0, in_rdy}, 36'h1);
    // R9: park a stale upper half, then reset
    in_word = {3'b001, 16'hDEAD}; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(out_vld == 1'b0, "R9 no output after reset", {35'b0, out_vld}, 36'h0);

    while (exp_rd < exp_n && cyc < LIMIT) begin
      int md;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      md = (in_rd < in_n) ? inmd[in_rd] : 0;
      in_vld  = (in_rd < in_n) && (md != 2 || lfsr[5]);
      in_word = (in_rd < in_n) ? inq[in_rd] : '0;
      out_rdy = (md == 0) ? 1'b1 : (md == 1) ? cyc[0] : (lfsr[0] | lfsr[3]);
      #1;
      if (prev_stall) begin
        // R6
        check(out_vld && out_word == prev_word, "R6 stalled word held", out_word, prev_word);
      end
      prev_stall = out_vld && !out_rdy;
      prev_word  = out_word;
      if (out_vld && !out_rdy) begin
        // R7
        check(in_rdy == 1'b0, "R7 in_rdy low in stall", {35'b0, in_rdy}, 36'h0);
      end
      if (out_vld && out_rdy) begin
        check(out_word == expq[exp_rd], exp_rd == 0 ? "R9 fresh start" : tag_of(expq[exp_rd]),
              out_word, expq[exp_rd]);
        exp_rd++;
      end
      if (in_vld && in_rdy) in_rd++;
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    in_vld = 1'b0; out_rdy = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    if (cyc >= LIMIT) check(1'b0, "watchdog expired", cyc, LIMIT);
    // R7 and R8: every half used, every word seen, nothing extra
    check(in_rd == in_n, "R7 all halves accepted", in_rd, in_n);
    check(exp_rd == exp_n, "R7 all words delivered", exp_rd, exp_n);
    check(out_vld == 1'b0, "R8 no leftover word", {35'b0, out_vld}, 36'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule